// File: doc/BRIEF.md
# Demand-Driven Two-Way Green Arbiter

This block decides which of two crossing roads, north-south and east-west, has the green light. Each road has one presence sensor and one green output. Green goes to whichever road has waiting cars. If cars wait on both roads, green swaps on every clock. If no car waits anywhere, the current green stays where it is.

The controller is a Moore machine with two states. Each output depends only on the registered state, so the lights never glitch with the sensors. A synchronous reset gives green to north-south. A parameter sets the sensor sample stage: zero uses the raw sensors, and one registers them for a cycle first. This adds one clock of latency to every decision.

Top module: `xing_green_ctrl`

## Requirements
- R1: While rst is high at a rising clock edge, the next state is north-south green. Outputs are then {ew_green,ns_green} = 2'b01.
- R2: Exactly one of ew_green and ns_green is high in every cycle after reset. The pair is 2'b01 in the north-south state and 2'b10 in the east-west state.
- R3: In the north-south state, sensors {ew_car,ns_car} = 2'b00 or 2'b01 keep the state at the next edge.
- R4: In the north-south state, sensors {ew_car,ns_car} = 2'b10 or 2'b11 move the state to east-west at the next edge.
- R5: In the east-west state, sensors {ew_car,ns_car} = 2'b00 or 2'b10 keep the state at the next edge.
- R6: In the east-west state, sensors {ew_car,ns_car} = 2'b01 or 2'b11 move the state to north-south at the next edge.
- R7: While both sensors stay high, the green swaps at every edge. With no traffic, the green holds for any number of cycles.
- R8: The outputs change only at a clock edge. A sensor change between edges has no effect on the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ew_car | input | 1 | A car is waiting on east-west |
| ns_car | input | 1 | A car is waiting on north-south |
| ew_green | output | 1 | East-west light is green |
| ns_green | output | 1 | North-south light is green |

## Verification
The bench drives all four sensor pairs from each of the two states, with the default zero-latency sampling. It compares the next state with a bench-side arbitration rule. This rule catches a design whose hold and move columns are crossed, for example one that leaves north-south when only north-south traffic is present. Long runs with both sensors high catch a machine that sticks in one state instead of swapping. Long idle runs catch one that drifts back to a default road. Sensor toggles between edges catch outputs that are wired through logic from the inputs (a Mealy leak) rather than taken from the state.

// File: rtl/xing_pkg.sv
package xing_pkg;
  typedef enum logic [0:0] {
    GREEN_NS = 1'b0,
    GREEN_EW = 1'b1
  } road_e;

  localparam int unsigned LIGHT_W = 2;

  // next-state rule: grant the other road when it has demand, otherwise stay
  function automatic road_e next_road(road_e cur, logic ew_req, logic ns_req);
    road_e nxt;
    nxt = cur;
    if (cur == GREEN_NS && ew_req) nxt = GREEN_EW;
    if (cur == GREEN_EW && ns_req) nxt = GREEN_NS;
    return nxt;
  endfunction

  // light pattern {ew,ns}
  function automatic logic [LIGHT_W-1:0] light_of(road_e st);
    return (st == GREEN_EW) ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/xing_sense.sv
module xing_sense #(
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic ew_raw,
  input  logic ns_raw,
  output logic ew_req,
  output logic ns_req
);
  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign ew_req = ew_raw;
      assign ns_req = ns_raw;
    end else begin : g_reg
      logic ew_q, ns_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          ew_q <= 1'b0;
          ns_q <= 1'b0;
        end else begin
          ew_q <= ew_raw;
          ns_q <= ns_raw;
        end
      end
      assign ew_req = ew_q;
      assign ns_req = ns_q;
    end
  endgenerate
endmodule

// File: rtl/xing_fsm.sv
module xing_fsm
  import xing_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ew_req,
  input  logic  ns_req,
  output road_e state,
  output logic  swap_evt
);
  road_e nxt;

  always_comb nxt = next_road(state, ew_req, ns_req);
  assign swap_evt = (nxt != state);

  always_ff @(posedge clk) begin
    if (rst) state <= GREEN_NS;
    else     state <= nxt;
  end

  // R3/R4: behaviour from the north-south state
  a_r3_ns_hold: assert property (@(posedge clk) disable iff (rst)
    (state == GREEN_NS && !ew_req) |=> state == GREEN_NS);
  a_r4_ns_leave: assert property (@(posedge clk) disable iff (rst)
    (state == GREEN_NS && ew_req) |=> state == GREEN_EW);
  // R5/R6: behaviour from the east-west state
  a_r5_ew_hold: assert property (@(posedge clk) disable iff (rst)
    (state == GREEN_EW && !ns_req) |=> state == GREEN_EW);
  a_r6_ew_leave: assert property (@(posedge clk) disable iff (rst)
    (state == GREEN_EW && ns_req) |=> state == GREEN_NS);
  // R7: both requests mean a swap; none means hold
  a_r7_alternate: assert property (@(posedge clk) disable iff (rst)
    (ew_req && ns_req) |=> state != $past(state));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ew_req && !ns_req) |=> $stable(state));
endmodule

// File: rtl/xing_lights.sv
module xing_lights
  import xing_pkg::*;
(
  input  road_e state,
  output logic  ew_green,
  output logic  ns_green
);
  logic [LIGHT_W-1:0] pat;
  always_comb pat = light_of(state);
  assign ew_green = pat[1];
  assign ns_green = pat[0];

  // R2: one green only
  always_comb begin
    a_r2_one_green: assert ($onehot({ew_green, ns_green}) || $isunknown(state));
  end
endmodule

// File: rtl/xing_green_ctrl.sv
module xing_green_ctrl
  import xing_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic ew_car,
  input  logic ns_car,
  output logic ew_green,
  output logic ns_green
);
  logic  ew_req, ns_req, swap_evt;
  road_e state;

  xing_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .ew_raw(ew_car), .ns_raw(ns_car),
    .ew_req(ew_req), .ns_req(ns_req)
  );

  xing_fsm u_fsm (
    .clk(clk), .rst(rst), .ew_req(ew_req), .ns_req(ns_req),
    .state(state), .swap_evt(swap_evt)
  );

  xing_lights u_lights (
    .state(state), .ew_green(ew_green), .ns_green(ns_green)
  );

  // R1: reset lands in the north-south state
  a_r1_reset_ns: assert property (@(posedge clk)
    rst |=> (ns_green && !ew_green));
  // R8: outputs move only when the machine announced a swap
  a_r8_moore_only: assert property (@(posedge clk) disable iff (rst)
    !swap_evt |=> $stable({ew_green, ns_green}));
  // R2: the pair toggles together on a swap
  a_r2_swap_flips: assert property (@(posedge clk) disable iff (rst)
    swap_evt |=> ew_green != $past(ew_green));
endmodule

// File: tb/xing_green_ctrl_tb.sv
module xing_green_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ew_car = 1'b0, ns_car = 1'b0;
  logic ew_green, ns_green;
  int   n_run = 0, n_fail = 0;
  bit   model_ew = 1'b0;

  always #2.5 clk = ~clk;

  xing_green_ctrl u_dut (
    .clk(clk), .rst(rst), .ew_car(ew_car), .ns_car(ns_car),
    .ew_green(ew_green), .ns_green(ns_green)
  );

  task automatic check(string req, logic [1:0] exp);
    n_run++;
    if ({ew_green, ns_green} !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, {ew_green, ns_green}, exp);
    end
  endtask

  function automatic logic [1:0] pat(bit ew);
    return ew ? 2'b10 : 2'b01;
  endfunction

  // apply sensors, clock once, check at the falling edge
  task automatic step(string req, bit e, bit n);
    ew_car = e; ns_car = n;
    @(posedge clk);
    // other road demanded -> move; else hold
    if (model_ew) model_ew = n ? 1'b0 : 1'b1;
    else          model_ew = e ? 1'b1 : 1'b0;
    @(negedge clk);
    check(req, pat(model_ew));
  endtask

  task automatic go_to(bit ew);
    if (model_ew != ew) step(ew ? "R4" : "R6", ew, !ew);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 2'b01);
    // exhaustive: each state x each sensor pair
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 4; p++) begin
        go_to(bit'(s));
        if (s == 0) step((p[1]) ? "R4" : "R3", p[1], p[0]);
        else        step((p[0]) ? "R6" : "R5", p[1], p[0]);
      end
    end
    // R7 alternation
    for (int i = 0; i < 7; i++) step("R7", 1'b1, 1'b1);
    // R7 idle hold in both states
    for (int i = 0; i < 6; i++) step("R7", 1'b0, 1'b0);
    go_to(~model_ew);
    for (int i = 0; i < 6; i++) step("R7", 1'b0, 1'b0);
    // R8: toggle sensors between edges; outputs must not move
    @(posedge clk);
    #1 ew_car = ~model_ew; ns_car = model_ew;
    #0.5 check("R8", pat(model_ew));
    ew_car = 1'b1; ns_car = 1'b1;
    #0.5 check("R8", pat(model_ew));
    ew_car = 1'b0; ns_car = 1'b0;
    @(negedge clk);
    check("R8", pat(model_ew));
    // R1 reset from east-west state
    go_to(1'b1);
    rst = 1'b1; ew_car = 1'b1; ns_car = 1'b0;
    @(negedge clk);
    check("R1", 2'b01);
    rst = 1'b0; ew_car = 1'b0; model_ew = 1'b0;
    // R2 in a long mixed run
    for (int i = 0; i < 32; i++) step("R2", bit'((i * 5 + 1) % 3 == 0), bit'(i % 2));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule